// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers five interrupt requests for a small CPU core and presents the winning one as an 8-bit vector address. There are two external pins (active low, each sensed by level or by falling edge), two timer overflow pulses and a level request from the serial port. Each source has its own enable bit. A global enable gates all five. Each source also carries a priority bit that places it in the high or the low group.

The CPU receives requests over a valid/ready pair. `irq_valid` is high while an eligible request exists, and `irq_vector` names it. A vector is taken in a cycle where both `irq_valid` and `irq_ready` are high. When `irq_ready` is low, nothing changes: latched requests stay pending and the in-service state keeps its value. The offer is re-evaluated every cycle, so a higher request may replace the one shown before it is taken.

Taking a vector marks its priority level as in service. While a low-level routine runs, only high-priority requests are offered. While a high-level routine runs, nothing is offered. A one-cycle `irq_ret` pulse ends the innermost active level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `irq_valid` is 0 and `svc_level` is 2'b00.
- R2: The vector of source index i is 8*i+3. The indices are 0 = external 0 (0x03), 1 = timer 0 (0x0B), 2 = external 1 (0x13), 3 = timer 1 (0x1B) and 4 = serial (0x23). Bit i of `src_en` and bit i of `prio_hi` belong to source i.
- R3: A source whose `src_en` bit is 0 is never offered. A latched request is kept while it is disabled and is offered once the source is enabled again.
- R4: While `glb_en` is 0, `irq_valid` is 0.
- R5: When any eligible high-priority request exists (`prio_hi` bit = 1), a high-priority source wins over every low-priority one.
- R6: Within one priority group, the lowest source index wins.
- R7: Taking a vector sets `svc_level[1]` for a high source and `svc_level[0]` for a low one. While `svc_level[1]` is set, nothing is offered. While only `svc_level[0]` is set, only high-priority requests are offered.
- R8: An `irq_ret` pulse clears `svc_level[1]` if it is set, and otherwise clears `svc_level[0]`.
- R9: In edge mode (`ext_edge` bit = 1), a falling edge on the pin latches a request. Taking that vector clears the latch, even while the pin stays low. A falling edge in the same cycle as the take keeps the latch set.
- R10: In level mode (`ext_edge` bit = 0), the request follows the inverted pin and is not cleared by a take.
- R11: A one-cycle timer overflow pulse latches a request that is held until its vector is taken.
- R12: A vector is taken only when `irq_valid` and `irq_ready` are both high. When a take and `irq_ret` fall in the same cycle, the return is applied first and the new level is set after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_pin_n | input | 2 | External interrupt pins, active low |
| ext_edge | input | 2 | Per-pin sense select: 1 = falling edge, 0 = level |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_req | input | 1 | Serial port request, level |
| src_en | input | 5 | Per-source enable |
| glb_en | input | 1 | Global enable |
| prio_hi | input | 5 | Per-source priority: 1 = high |
| irq_valid | output | 1 | A request is offered |
| irq_ready | input | 1 | CPU takes the offered vector |
| irq_vector | output | 8 | Vector address of the offered request |
| irq_ret | input | 1 | Return-from-interrupt pulse |
| svc_level | output | 2 | In-service levels: bit 1 = high, bit 0 = low |

## Verification
Two pairs of events can fall in the same cycle. First, a vector take can coincide with a return pulse. The bench provokes this with a low routine in service and a high request waiting, then raises `irq_ready` and `irq_ret` together. It judges the result by `svc_level`, which must read 2'b10. Second, a new falling edge can arrive on an edge-mode pin in the very cycle its vector is taken. After the return, the request must be offered again with the same vector. A scoreboard queue holds the vector expected at every take, in the order the priority and polling rules predict.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC     = 5;
  localparam int VEC_W    = 8;
  localparam int VEC_BASE = 3;
  localparam int VEC_STEP = 8;

  typedef enum logic [1:0] {SRC_EXT, SRC_PULSE, SRC_LEVEL} src_kind_e;

  function automatic src_kind_e kind_of(input int idx);
    if (idx == NSRC - 1) return SRC_LEVEL;
    return (idx % 2 == 0) ? SRC_EXT : SRC_PULSE;
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input int idx);
    return VEC_W'(idx * VEC_STEP + VEC_BASE);
  endfunction
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch
  import irq_pkg::*;
#(
  parameter src_kind_e KIND = SRC_EXT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  input  logic edge_mode_i,
  input  logic take_i,
  output logic req_o
);
  logic pin_q, flag_q, flag_d, fall, set;

  always_comb begin
    fall = pin_q & ~sig_i;
    unique case (KIND)
      SRC_EXT:   set = edge_mode_i & fall;
      SRC_PULSE: set = sig_i;
      default:   set = 1'b0;
    endcase
    if (KIND == SRC_EXT && !edge_mode_i) flag_d = 1'b0;
    else                                  flag_d = set | (flag_q & ~take_i);
    unique case (KIND)
      SRC_EXT:   req_o = edge_mode_i ? flag_q : ~sig_i;
      SRC_PULSE: req_o = flag_q;
      default:   req_o = sig_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      pin_q  <= sig_i;
      flag_q <= flag_d;
    end
  end

  p_edge_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (KIND == SRC_EXT && edge_mode_i && pin_q && !sig_i) |=> flag_q);
  p_pulse_latch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (KIND == SRC_PULSE && sig_i) |=> req_o);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N     = 5,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req_i,
  input  logic [N-1:0]     prio_hi_i,
  input  logic [1:0]       svc_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     grant_o,
  output logic             hi_o
);
  logic [N-1:0] hi_set, lo_set, pick;

  always_comb begin
    hi_set = req_i & prio_hi_i;
    lo_set = req_i & ~prio_hi_i;
    if (svc_i[1])      pick = '0;
    else if (|hi_set)  pick = hi_set;
    else if (svc_i[0]) pick = '0;
    else               pick = lo_set;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (pick[i]) idx_o = IDX_W'(i);
    valid_o = |pick;
    grant_o = valid_o ? (N'(1) << idx_o) : '0;
    hi_o    = valid_o & prio_hi_i[idx_o];
  end

  p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && ((grant_o & ~req_i) == '0));
  p_hi_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && |(req_i & prio_hi_i)) |-> hi_o);
  p_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_i[1] |-> !valid_o);
  p_nest_hi_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_i[0] && valid_o) |-> hi_o);
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take_i,
  input  logic       take_hi_i,
  input  logic       ret_i,
  output logic [1:0] svc_o
);
  logic [1:0] svc_q, after_ret, svc_d;

  always_comb begin
    after_ret = svc_q;
    if (ret_i) after_ret = svc_q[1] ? {1'b0, svc_q[0]} : 2'b00;
    svc_d = after_ret;
    if (take_i) svc_d = svc_d | (take_hi_i ? 2'b10 : 2'b01);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= 2'b00;
    else        svc_q <= svc_d;
  end

  assign svc_o = svc_q;

  p_take_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && take_hi_i) |=> svc_q[1]);
  p_ret_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !take_i && svc_q[1]) |=> (!svc_q[1] && svc_q[0] == $past(svc_q[0])));
  p_ret_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !take_i && !svc_q[1]) |=> (svc_q == 2'b00));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ext_pin_n,
  input  logic [1:0]       ext_edge,
  input  logic [1:0]       tmr_ovf,
  input  logic             ser_req,
  input  logic [NSRC-1:0]  src_en,
  input  logic             glb_en,
  input  logic [NSRC-1:0]  prio_hi,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [VEC_W-1:0] irq_vector,
  input  logic             irq_ret,
  output logic [1:0]       svc_level
);
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]  raw_req, elig, grant, take;
  logic [IDX_W-1:0] win_idx;
  logic             win_hi, fire;

  assign fire = irq_valid & irq_ready;
  assign take = fire ? grant : '0;
  assign elig = glb_en ? (raw_req & src_en) : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam src_kind_e K = kind_of(i);
    logic sig, emode;
    if (K == SRC_EXT) begin : g_ext
      assign sig   = ext_pin_n[i/2];
      assign emode = ext_edge[i/2];
    end else if (K == SRC_PULSE) begin : g_tmr
      assign sig   = tmr_ovf[i/2];
      assign emode = 1'b0;
    end else begin : g_lvl
      assign sig   = ser_req;
      assign emode = 1'b0;
    end
    irq_src_latch #(.KIND(K)) u_latch (
      .clk(clk), .rst_n(rst_n), .sig_i(sig), .edge_mode_i(emode),
      .take_i(take[i]), .req_o(raw_req[i])
    );
  end

  irq_arbiter #(.N(NSRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .req_i(elig), .prio_hi_i(prio_hi),
    .svc_i(svc_level), .valid_o(irq_valid), .idx_o(win_idx),
    .grant_o(grant), .hi_o(win_hi)
  );

  irq_svc_track u_svc (
    .clk(clk), .rst_n(rst_n), .take_i(fire), .take_hi_i(win_hi),
    .ret_i(irq_ret), .svc_o(svc_level)
  );

  always_comb begin
    irq_vector = '0;
    for (int i = 0; i < NSRC; i++)
      if (win_idx == IDX_W'(i)) irq_vector = vec_of(i);
  end

  p_glb_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !irq_valid);
  p_src_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> src_en[win_idx]);
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_ready && !irq_ret) |=> $stable(svc_level));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] vec;
    string      tag;
  } exp_t;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] ext_pin_n = 2'b11, ext_edge = 2'b11, tmr_ovf = 2'b00;
  logic       ser_req = 1'b0, glb_en = 1'b1, irq_ready = 1'b0, irq_ret = 1'b0;
  logic [4:0] src_en = 5'b11111, prio_hi = 5'b00000;
  logic       irq_valid;
  logic [7:0] irq_vector;
  logic [1:0] svc_level;

  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .ext_edge(ext_edge),
    .tmr_ovf(tmr_ovf), .ser_req(ser_req), .src_en(src_en), .glb_en(glb_en),
    .prio_hi(prio_hi), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_vector(irq_vector), .irq_ret(irq_ret), .svc_level(svc_level)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic probe(input string tag, input logic v, input logic [1:0] s);
    @(negedge clk);
    chk({tag, " valid"}, 32'(irq_valid), 32'(v));
    chk({tag, " svc"}, 32'(svc_level), 32'(s));
  endtask

  task automatic probe_vec(input string tag, input logic [7:0] v);
    @(negedge clk);
    chk({tag, " offer"}, 32'(irq_valid), 32'd1);
    chk({tag, " vector"}, 32'(irq_vector), 32'(v));
  endtask

  task automatic take(input logic [7:0] v, input string tag);
    exp_t e;
    e.vec = v;
    e.tag = tag;
    exp_q.push_back(e);
    irq_ready = 1'b1;
    tick();
    irq_ready = 1'b0;
  endtask

  task automatic ret();
    irq_ret = 1'b1;
    tick();
    irq_ret = 1'b0;
  endtask

  task automatic pulse(input logic [1:0] t);
    tmr_ovf = t;
    tick();
    tmr_ovf = 2'b00;
  endtask

  // monitor: compares every take against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && irq_ready) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R12: take with no expected item, actual %0h expected none", irq_vector);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " R2 take valid"}, 32'(irq_valid), 32'd1);
        chk({e.tag, " R2 take vector"}, 32'(irq_vector), 32'(e.vec));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    probe("R1 reset", 1'b0, 2'b00);

    // R4 global mask, R11 pulse held
    glb_en = 1'b0;
    pulse(2'b01);
    probe("R4 global off", 1'b0, 2'b00);
    glb_en = 1'b1;
    probe_vec("R11 held pulse", 8'h0B);
    take(8'h0B, "R11");
    probe("R7 low in service", 1'b0, 2'b01);
    ret();
    probe("R8 ret low", 1'b0, 2'b00);

    // R3 per-source enable
    src_en = 5'b10111;
    pulse(2'b10);
    probe("R3 disabled", 1'b0, 2'b00);
    tick(); tick();
    src_en = 5'b11111;
    probe_vec("R3 re-enabled", 8'h1B);
    take(8'h1B, "R3");
    ret();

    // R12 no take without ready
    pulse(2'b01);
    tick(); tick(); tick();
    probe("R12 no ready", 1'b1, 2'b00);
    take(8'h0B, "R12");
    ret();

    // R6 polling order, all low
    ext_edge = 2'b01;
    ext_pin_n = 2'b00;
    ser_req = 1'b1;
    pulse(2'b11);
    take(8'h03, "R6 ext0");   ret();
    take(8'h0B, "R6 tmr0");   ret();
    take(8'h13, "R6 ext1");   ext_pin_n[1] = 1'b1; ret();
    take(8'h1B, "R6 tmr1");   ret();
    take(8'h23, "R6 serial"); ser_req = 1'b0; ret();
    probe("R9 edge pin still low", 1'b0, 2'b00);
    ext_pin_n = 2'b11;
    ext_edge = 2'b11;

    // R5 high group wins over lower index
    prio_hi = 5'b01000;
    pulse(2'b11);
    probe_vec("R5 high first", 8'h1B);
    take(8'h1B, "R5");
    probe("R7 high blocks all", 1'b0, 2'b10);
    ret();
    take(8'h0B, "R5 low after");
    ret();

    // R7 nesting
    pulse(2'b01);
    take(8'h0B, "R7 low");
    ser_req = 1'b1;
    probe("R7 low blocks low", 1'b0, 2'b01);
    pulse(2'b10);
    probe_vec("R7 high nests", 8'h1B);
    take(8'h1B, "R7 nest");
    probe("R7 two deep", 1'b0, 2'b11);
    ret();
    probe("R8 ret clears high", 1'b0, 2'b01);
    ret();
    probe_vec("R8 low cleared", 8'h23);
    ser_req = 1'b0;
    probe("R10 serial gone", 1'b0, 2'b00);

    // R9 new edge in the take cycle
    ext_pin_n[0] = 1'b0;
    tick();
    ext_pin_n[0] = 1'b1;
    tick();
    ext_pin_n[0] = 1'b0;
    take(8'h03, "R9 collide");
    ext_pin_n[0] = 1'b1;
    probe("R9 blocked during low", 1'b0, 2'b01);
    ret();
    probe_vec("R9 relatched", 8'h03);
    take(8'h03, "R9 second");
    ret();
    probe("R9 cleared", 1'b0, 2'b00);

    // R10 level mode
    ext_edge[1] = 1'b0;
    ext_pin_n[1] = 1'b0;
    probe_vec("R10 level immediate", 8'h13);
    take(8'h13, "R10");
    ret();
    probe_vec("R10 level persists", 8'h13);
    ext_pin_n[1] = 1'b1;
    probe("R10 level released", 1'b0, 2'b00);
    ext_edge[1] = 1'b1;

    // R12 take and return together
    pulse(2'b01);
    take(8'h0B, "R12 low");
    pulse(2'b10);
    begin
      exp_t e;
      e.vec = 8'h1B;
      e.tag = "R12 with ret";
      exp_q.push_back(e);
    end
    irq_ready = 1'b1;
    irq_ret = 1'b1;
    tick();
    irq_ready = 1'b0;
    irq_ret = 1'b0;
    probe("R12 ret then take", 1'b0, 2'b10);
    ret();
    probe("R8 final", 1'b0, 2'b00);

    chk("R2 scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule